// File: doc/BRIEF.md
# Receive Interrupt Coalescing Watchdog

This block holds back the receive-complete interrupt for frames whose descriptor asked for it to be withheld, and raises the interrupt anyway once a programmable quiet time has passed. When the receive DMA reports a finished frame with the withhold flag set, a timer is loaded. It counts down in units of 2^PRE_W clock cycles, which is 256 cycles at the default setting. When it reaches the end, it sets the sticky receive-interrupt status bit and stops. A finished frame without the withhold flag sets the status bit at once and cancels any countdown in progress.

All pins are plain control and status signals. No data stream passes through the block, so there is no valid/ready handshake. Each frame completion is a one-cycle pulse, and the withhold flag is sampled in the same cycle as that pulse. The status bit stays set until software clears it with a one-cycle clear pulse. A timeout value of zero turns the watchdog off.

Top module: `riw_watchdog`

## Requirements
- R1: After reset the status bit is 0, the running indication is 0 and the timeout register reads 0.
- R2: A completion pulse with the withhold flag at 0 sets the status bit on the next edge and halts a running timer in the same edge.
- R3: A completion pulse with the withhold flag at 1 and a nonzero timeout raises the running indication on the next edge and leaves the status bit unchanged.
- R4: If nothing else happens, the status bit rises and the running indication falls exactly V×2^PRE_W cycles after the edge that started the timer, where V is the timeout value at that edge.
- R5: With a timeout of 0, a completion with the withhold flag does not start the timer and does not set the status bit.
- R6: A further withheld completion while the timer runs restarts the countdown from the full current timeout value.
- R7: The status bit holds until a clear pulse. A clear pulse with no set event drops it on the next edge. A set event and a clear in the same cycle leave it at 1.
- R8: Writing the timeout register while the timer runs does not change the countdown in progress. The new value is used from the next start onward.
- R9: A write pulse loads the timeout register, and the new value appears on the readback port after the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tmo_wr_en | input | 1 | Timeout register write strobe |
| tmo_wr_data | input | CNT_W | Timeout value to write |
| tmo_value | output | CNT_W | Timeout register readback |
| frame_done | input | 1 | One-cycle pulse when a received frame has been transferred |
| frame_suppress | input | 1 | The frame's descriptor asks to withhold the interrupt |
| irq_clr | input | 1 | Write-1-to-clear pulse for the status bit |
| irq_status | output | 1 | Sticky receive-interrupt status bit |
| timer_running | output | 1 | The watchdog countdown is active |

## Verification
The bench builds the block with CNT_W=8 and PRE_W=3, so one tick is 8 cycles and the longest timeout is 2040 cycles. This lets the exact expiry cycle be checked for many timeout values, and also for restarts, cancels and writes made in the middle of a countdown, within a short run. The prescaler wrap and the last-tick comparison work the same way at the default width. Only the length of each tick changes.

// File: rtl/riw_pkg.sv
package riw_pkg;
  // decoded completion event for one cycle
  typedef struct packed {
    logic arm;     // withheld completion, watchdog enabled
    logic cancel;  // normal completion, interrupt raised directly
  } riw_evt_t;
endpackage

// File: rtl/riw_event_decode.sv
module riw_event_decode
  import riw_pkg::*;
(
  input  logic     frame_done,
  input  logic     frame_suppress,
  input  logic     tmo_nonzero,
  output riw_evt_t evt
);
  always_comb begin
    evt.arm    = frame_done & frame_suppress & tmo_nonzero;
    evt.cancel = frame_done & ~frame_suppress;
  end
endmodule

// File: rtl/riw_prescaler.sv
module riw_prescaler #(
  parameter int PRE_W = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  input  logic enable,
  output logic tick
);
  logic [PRE_W-1:0] pre_q;

  always_ff @(posedge clk) begin
    if (!rst_n)       pre_q <= '0;
    else if (restart) pre_q <= '0;
    else if (enable)  pre_q <= pre_q + PRE_W'(1);
  end

  // one tick per full wrap of the divider
  assign tick = enable & (&pre_q);
endmodule

// File: rtl/riw_tick_counter.sv
module riw_tick_counter #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             cancel,
  input  logic             tick,
  output logic             running,
  output logic             expire
);
  logic [CNT_W-1:0] left_q;
  logic             run_q;
  logic             last_tick;

  assign last_tick = run_q & tick & (left_q == CNT_W'(1));
  assign expire    = last_tick & ~load & ~cancel;
  assign running   = run_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      left_q <= '0;
    end else if (load) begin
      run_q  <= 1'b1;
      left_q <= load_val;
    end else if (cancel) begin
      run_q  <= 1'b0;
    end else if (run_q && tick) begin
      if (last_tick) run_q  <= 1'b0;
      else           left_q <= left_q - CNT_W'(1);
    end
  end
endmodule

// File: rtl/riw_status.sv
module riw_status (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  output logic status
);
  always_ff @(posedge clk) begin
    if (!rst_n)   status <= 1'b0;
    else if (set) status <= 1'b1;
    else if (clr) status <= 1'b0;
  end
endmodule

// File: rtl/riw_watchdog.sv
module riw_watchdog
  import riw_pkg::*;
#(
  parameter int CNT_W = 8,
  parameter int PRE_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tmo_wr_en,
  input  logic [CNT_W-1:0] tmo_wr_data,
  output logic [CNT_W-1:0] tmo_value,
  input  logic             frame_done,
  input  logic             frame_suppress,
  input  logic             irq_clr,
  output logic             irq_status,
  output logic             timer_running
);
  logic [CNT_W-1:0] tmo_q;
  riw_evt_t         evt;
  logic             tick;
  logic             expire;

  always_ff @(posedge clk) begin
    if (!rst_n)         tmo_q <= '0;
    else if (tmo_wr_en) tmo_q <= tmo_wr_data;
  end
  assign tmo_value = tmo_q;

  riw_event_decode u_dec (
    .frame_done     (frame_done),
    .frame_suppress (frame_suppress),
    .tmo_nonzero    (|tmo_q),
    .evt            (evt)
  );

  riw_prescaler #(.PRE_W(PRE_W)) u_pre (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (evt.arm),
    .enable  (timer_running),
    .tick    (tick)
  );

  riw_tick_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (evt.arm),
    .load_val (tmo_q),
    .cancel   (evt.cancel),
    .tick     (tick),
    .running  (timer_running),
    .expire   (expire)
  );

  riw_status u_sts (
    .clk    (clk),
    .rst_n  (rst_n),
    .set    (expire | evt.cancel),
    .clr    (irq_clr),
    .status (irq_status)
  );
endmodule

// File: rtl/riw_watchdog_chk.sv
module riw_watchdog_chk #(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic [CNT_W-1:0] tmo_value,
  input logic             frame_done,
  input logic             frame_suppress,
  input logic             irq_clr,
  input logic             irq_status,
  input logic             timer_running
);
  a_r2_normal_sets: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done && !frame_suppress |=> irq_status && !timer_running);

  a_r3_arm_runs: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done && frame_suppress && (tmo_value != '0) |=> timer_running);

  a_r5_zero_idle: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done && frame_suppress && (tmo_value == '0) && !timer_running
    |=> !timer_running);

  a_r7_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    irq_status && !irq_clr |=> irq_status);

  a_r7_clear: assert property (@(posedge clk) disable iff (!rst_n)
    irq_clr && !timer_running && !(frame_done && !frame_suppress) |=> !irq_status);

  a_r4_expiry_sets: assert property (@(posedge clk) disable iff (!rst_n)
    timer_running && !frame_done && !irq_clr ##1 !timer_running |-> irq_status);
endmodule

bind riw_watchdog riw_watchdog_chk #(.CNT_W(CNT_W)) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .tmo_value      (tmo_value),
  .frame_done     (frame_done),
  .frame_suppress (frame_suppress),
  .irq_clr        (irq_clr),
  .irq_status     (irq_status),
  .timer_running  (timer_running)
);

// File: tb/tb_riw_watchdog.sv
module tb_riw_watchdog;
  localparam int CLK_PERIOD = 10;
  localparam int CNT_W = 8;
  localparam int PRE_W = 3;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             tmo_wr_en = 1'b0;
  logic [CNT_W-1:0] tmo_wr_data = '0;
  logic [CNT_W-1:0] tmo_value;
  logic             frame_done = 1'b0;
  logic             frame_suppress = 1'b0;
  logic             irq_clr = 1'b0;
  logic             irq_status;
  logic             timer_running;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  riw_watchdog #(.CNT_W(CNT_W), .PRE_W(PRE_W)) dut (
    .clk(clk), .rst_n(rst_n), .tmo_wr_en(tmo_wr_en), .tmo_wr_data(tmo_wr_data),
    .tmo_value(tmo_value), .frame_done(frame_done), .frame_suppress(frame_suppress),
    .irq_clr(irq_clr), .irq_status(irq_status), .timer_running(timer_running)
  );

  function automatic int exp_cycles(int v);
    return v << PRE_W;
  endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #1;
    end
  endtask

  task automatic wr_tmo(int v);
    tmo_wr_en = 1'b1; tmo_wr_data = CNT_W'(v);
    step();
    tmo_wr_en = 1'b0;
  endtask

  task automatic frame(logic sup);
    frame_done = 1'b1; frame_suppress = sup;
    step();
    frame_done = 1'b0; frame_suppress = 1'b0;
  endtask

  task automatic clear();
    irq_clr = 1'b1;
    step();
    irq_clr = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++; checks++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int n;
    void'($urandom(32'd1234));
    step(3);
    // R1 reset state
    chk("R1 status", irq_status, 0);
    chk("R1 running", timer_running, 0);
    chk("R1 timeout", tmo_value, 0);
    rst_n = 1'b1;
    step();

    // R5 disabled watchdog
    frame(1'b1);
    chk("R5 running", timer_running, 0);
    step(20);
    chk("R5 status", irq_status, 0);

    // R9 register write
    wr_tmo(3);
    chk("R9 readback", tmo_value, 3);

    // R2 normal completion, R7 clear
    frame(1'b0);
    chk("R2 status", irq_status, 1);
    step(5);
    chk("R7 sticky", irq_status, 1);
    clear();
    chk("R7 cleared", irq_status, 0);

    // R3/R4 basic expiry
    frame(1'b1);
    n = exp_cycles(3);
    chk("R3 running", timer_running, 1);
    chk("R3 status", irq_status, 0);
    step(n - 1);
    chk("R4 running before", timer_running, 1);
    chk("R4 status before", irq_status, 0);
    step();
    chk("R4 status at expiry", irq_status, 1);
    chk("R4 running at expiry", timer_running, 0);
    step(10);
    chk("R7 sticky after expiry", irq_status, 1);

    // R7 set wins over clear
    irq_clr = 1'b1; frame_done = 1'b1; frame_suppress = 1'b0;
    step();
    irq_clr = 1'b0; frame_done = 1'b0;
    chk("R7 set over clear", irq_status, 1);
    clear();

    // R6 restart
    wr_tmo(2);
    frame(1'b1);
    step(10);
    frame(1'b1);
    n = exp_cycles(2);
    step(n - 1);
    chk("R6 still running", timer_running, 1);
    chk("R6 status before", irq_status, 0);
    step();
    chk("R6 status at expiry", irq_status, 1);
    clear();

    // R2 cancel while running
    frame(1'b1);
    step(5);
    frame(1'b0);
    chk("R2 cancel running", timer_running, 0);
    chk("R2 cancel status", irq_status, 1);
    clear();
    step(30);
    chk("R2 no late expiry", irq_status, 0);

    // R8 write during run
    frame(1'b1);
    step(2);
    wr_tmo(9);
    step(exp_cycles(2) - 4);
    chk("R8 old running", timer_running, 1);
    step();
    chk("R8 old value expiry", irq_status, 1);
    clear();
    frame(1'b1);
    step(exp_cycles(9) - 1);
    chk("R8 new running", timer_running, 1);
    step();
    chk("R8 new value expiry", irq_status, 1);
    clear();

    // random timeouts, optional cancel
    for (int it = 0; it < 20; it++) begin
      int v, cut;
      v = 1 + int'($urandom % 40);
      wr_tmo(v);
      frame(1'b1);
      n = exp_cycles(v);
      if ($urandom % 4 == 0) begin
        cut = int'($urandom % (n - 1));
        step(cut);
        frame(1'b0);
        chk("R2 random cancel", timer_running, 0);
        chk("R2 random cancel status", irq_status, 1);
      end else begin
        step(n - 1);
        chk("R4 random before", irq_status, 0);
        step();
        chk("R4 random expiry", irq_status, 1);
      end
      clear();
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule